// File: doc/BRIEF.md
# Four-Function ALU with Condition Flags

This unit is the arithmetic core of a 32-bit datapath. It takes two operand words and a 2-bit function selector. It returns one result word together with three condition flags: signed overflow, zero and carry/borrow. The selector picks addition, subtraction, bitwise AND or bitwise XOR.

The unit holds no state and has no clock. Every output is a pure function of the present inputs, so a surrounding pipeline can register the result and flags wherever its timing allows. Addition and subtraction share a single carry chain: subtraction inverts the second operand and injects a carry-in of one. The flags are derived from that shared chain and from the selected result.

Top module: `alu4_flags`

## Requirements
- R1: With `func_sel` = 0, `result` equals `op_a + op_b` modulo 2^32.
- R2: With `func_sel` = 1, `result` equals `op_a - op_b` modulo 2^32.
- R3: With `func_sel` = 2, `result` equals the bitwise AND of the operands.
- R4: With `func_sel` = 3, `result` equals the bitwise XOR of the operands.
- R5: `flag_zero` is 1 exactly when all 32 bits of `result` are 0, under every selector value.
- R6: With `func_sel` = 0, `flag_ovf` is 1 exactly when both operands carry the same sign bit (bit 31) and the sign bit of `result` differs from it.
- R7: With `func_sel` = 1, `flag_ovf` is 1 exactly when the operand sign bits differ and the sign bit of `result` differs from that of `op_a`.
- R8: With `func_sel` = 0, `flag_carry` is the carry out of bit 31 of the addition.
- R9: With `func_sel` = 1, `flag_carry` is the borrow: 1 exactly when `op_a` is less than `op_b` as unsigned numbers.
- R10: With `func_sel` = 2 or 3, `flag_ovf` and `flag_carry` are both 0.
- R11: The outputs follow a change on any input without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand (minuend for subtraction) |
| op_b | input | 32 | Second operand (subtrahend for subtraction) |
| func_sel | input | 2 | Operation: 0 add, 1 subtract, 2 AND, 3 XOR |
| result | output | 32 | Result word of the selected operation |
| flag_ovf | output | 1 | Signed overflow flag |
| flag_zero | output | 1 | Result-is-zero flag |
| flag_carry | output | 1 | Carry out for add, borrow for subtract, else 0 |

## Verification
The bench drives the largest positive word plus one, the most negative word minus one, zero minus one and an operand combined with itself, under every selector value, and then sends random vectors. A design that takes the subtraction flag straight from the raw carry out would report the borrow inverted at 0-1 and at X-X. A design that uses the addition overflow rule for subtraction would miss the overflow at 0x80000000-1. A design that leaves the adder's carry on the logic codes would show a spurious carry on AND and XOR. A design that derives the zero flag from the adder alone would get X^X and X&0 wrong.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    // Operation selector; the encoding is fixed by the port contract.
    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } alu_fn_e;

    typedef struct packed {
        logic ovf;
        logic zero;
        logic carry;
    } alu_flags_t;

endpackage

// File: rtl/alu4_addsub.sv
// Shared carry chain for add and subtract; subtract inverts b and adds one.
module alu4_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = full[W-1:0];
        cout  = full[W];
        // Same-sign inputs to the chain with a sign change at the output.
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu4_bitwise.sv
// Per-bit AND and XOR lanes.
module alu4_bitwise #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_out,
    output logic [W-1:0] xor_out
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign and_out[i] = a[i] & b[i];
        assign xor_out[i] = a[i] ^ b[i];
    end
endmodule

// File: rtl/alu4_zero_detect.sv
// Zero detection as a two-level OR tree over fixed-size groups.
module alu4_zero_detect #(
    parameter int W     = 32,
    parameter int GROUP = 8
) (
    input  logic [W-1:0] value,
    output logic         is_zero
);
    localparam int NGRP = (W + GROUP - 1) / GROUP;
    localparam int PADW = NGRP * GROUP;

    logic [PADW-1:0] padded;
    logic [NGRP-1:0] grp_any;

    assign padded = {{(PADW - W){1'b0}}, value};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_any[g] = |padded[g*GROUP +: GROUP];
    end

    assign is_zero = ~|grp_any;
endmodule

// File: rtl/alu4_flags.sv
module alu4_flags
    import alu4_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   func_sel,
    output logic [W-1:0] result,
    output logic         flag_ovf,
    output logic         flag_zero,
    output logic         flag_carry
);
    typedef struct packed {
        logic [W-1:0] res;
        alu_flags_t   fl;
    } alu_out_t;

    alu_fn_e      fn;
    logic         is_sub;
    logic [W-1:0] sum;
    logic         cout;
    logic         ovf_arith;
    logic [W-1:0] and_v;
    logic [W-1:0] xor_v;
    logic [W-1:0] res_sel_d;
    logic         zero_d;
    alu_out_t     out_d;

    assign fn     = alu_fn_e'(func_sel);
    assign is_sub = (fn == FN_SUB);

    alu4_addsub #(.W(W)) u_addsub (
        .a    (op_a),
        .b    (op_b),
        .sub  (is_sub),
        .sum  (sum),
        .cout (cout),
        .ovf  (ovf_arith)
    );

    alu4_bitwise #(.W(W)) u_bitwise (
        .a       (op_a),
        .b       (op_b),
        .and_out (and_v),
        .xor_out (xor_v)
    );

    always_comb begin
        unique case (fn)
            FN_ADD,
            FN_SUB:  res_sel_d = sum;
            FN_AND:  res_sel_d = and_v;
            default: res_sel_d = xor_v;
        endcase
    end

    alu4_zero_detect #(.W(W), .GROUP(8)) u_zero (
        .value   (res_sel_d),
        .is_zero (zero_d)
    );

    always_comb begin
        out_d         = '0;
        out_d.res     = res_sel_d;
        out_d.fl.zero = zero_d;
        unique case (fn)
            FN_ADD: begin
                out_d.fl.ovf   = ovf_arith;
                out_d.fl.carry = cout;
            end
            FN_SUB: begin
                out_d.fl.ovf   = ovf_arith;
                out_d.fl.carry = ~cout;     // no carry out means a borrow
            end
            default: begin
                out_d.fl.ovf   = 1'b0;
                out_d.fl.carry = 1'b0;
            end
        endcase
    end

    assign result     = out_d.res;
    assign flag_ovf   = out_d.fl.ovf;
    assign flag_zero  = out_d.fl.zero;
    assign flag_carry = out_d.fl.carry;
endmodule

// File: rtl/alu4_checker.sv
module alu4_checker #(
    parameter int W = 32
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [1:0]   func_sel,
    input logic [W-1:0] result,
    input logic         flag_ovf,
    input logic         flag_zero,
    input logic         flag_carry
);
    logic [W:0] wide_add;
    assign wide_add = {1'b0, op_a} + {1'b0, op_b};

    always_comb begin
        AST_ZERO_MATCH: assert (flag_zero == (result == '0)) else $error("zero flag mismatch"); // R5
        if (func_sel == 2'd0) begin
            AST_ADD_RESULT: assert (result == wide_add[W-1:0]) else $error("add result"); // R1
            AST_ADD_CARRY: assert (flag_carry == wide_add[W]) else $error("add carry"); // R8
        end
        if (func_sel == 2'd1) begin
            AST_SUB_RESULT: assert (result + op_b == op_a) else $error("sub result"); // R2
            AST_SUB_BORROW: assert (flag_carry == (op_a < op_b)) else $error("sub borrow"); // R9
        end
        if (func_sel == 2'd2) begin
            AST_AND_RESULT: assert ((result & ~op_a) == '0 && (result & ~op_b) == '0) else $error("and result"); // R3
        end
        if (func_sel == 2'd3) begin
            AST_XOR_RESULT: assert ((result ^ op_b) == op_a) else $error("xor result"); // R4
        end
        if (func_sel[1]) begin
            AST_LOGIC_FLAGS_CLEAR: assert (!flag_ovf && !flag_carry) else $error("logic flags"); // R10
        end
    end
endmodule

bind alu4_flags alu4_checker #(.W(W)) u_checker (
    .op_a       (op_a),
    .op_b       (op_b),
    .func_sel   (func_sel),
    .result     (result),
    .flag_ovf   (flag_ovf),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry)
);

// File: tb/alu4_flags_test.sv
module alu4_flags_test;
    localparam int W = 32;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [1:0]   op;
        logic [W-1:0] res;
        logic         of;
        logic         zf;
        logic         cf;
    } exp_t;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [1:0]   func_sel = 2'd0;
    logic [W-1:0] result;
    logic         flag_ovf, flag_zero, flag_carry;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    alu4_flags #(.W(W)) uut (
        .op_a       (op_a),
        .op_b       (op_b),
        .func_sel   (func_sel),
        .result     (result),
        .flag_ovf   (flag_ovf),
        .flag_zero  (flag_zero),
        .flag_carry (flag_carry)
    );

    function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] op);
        exp_t e;
        longint sa, sb, s;
        logic [W:0] wide;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        e.a = a; e.b = b; e.op = op;
        e.of = 1'b0; e.cf = 1'b0;
        case (op)
            2'd0: begin
                wide  = {1'b0, a} + {1'b0, b};
                e.res = wide[W-1:0];
                e.cf  = wide[W];
                s     = sa + sb;
                e.of  = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            2'd1: begin
                e.res = a - b;
                e.cf  = (a < b);
                s     = sa - sb;
                e.of  = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            2'd2: e.res = a & b;
            default: e.res = a ^ b;
        endcase
        e.zf = (e.res == '0);
        return e;
    endfunction

    function automatic string res_tag(logic [1:0] op);
        case (op)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic string of_tag(logic [1:0] op);
        case (op)
            2'd0: return "R6";
            2'd1: return "R7";
            default: return "R10";
        endcase
    endfunction

    function automatic string cf_tag(logic [1:0] op);
        case (op)
            2'd0: return "R8";
            2'd1: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: apply a vector after a rising edge and queue its expectation.
    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] op);
        @(posedge clk);
        op_a = a; op_b = b; func_sel = op;
        q.push_back(model(a, b, op));
    endtask

    // Monitor: compare at the falling edge, half a period after the driver.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(result == e.res, res_tag(e.op), "result", result, e.res);
            check(flag_zero == e.zf, "R5", "zero", W'(flag_zero), W'(e.zf));
            check(flag_ovf == e.of, of_tag(e.op), "ovf", W'(flag_ovf), W'(e.of));
            check(flag_carry == e.cf, cf_tag(e.op), "carry", W'(flag_carry), W'(e.cf));
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] same [4];
        same[0] = 32'h1234_5678; same[1] = 32'h0;
        same[2] = 32'hFFFF_FFFF; same[3] = 32'h8000_0000;

        // Idle state with all-zero inputs: add of zeros gives zero, flag set (R5).
        #1;
        check(result == '0, "R1", "idle result", result, '0);
        check(flag_zero == 1'b1, "R5", "idle zero", W'(flag_zero), W'(1));

        for (int op = 0; op < 4; op++) begin
            drive(32'h7FFF_FFFF, 32'h1, 2'(op));       // R6 overflow on add
            drive(32'h8000_0000, 32'h1, 2'(op));       // R7 overflow on sub
            drive(32'h0,         32'h1, 2'(op));       // R9 borrow
            for (int k = 0; k < 4; k++)
                drive(same[k], same[k], 2'(op));       // X op X
            drive(32'hFFFF_FFFF, 32'h1, 2'(op));       // R8 carry, zero sum
            drive(32'h8000_0000, 32'h8000_0000, 2'(op));
            drive(32'h0F0F_0F0F, 32'hF0F0_F0F0, 2'(op)); // R3 disjoint bits
            drive(32'h1,         32'h0, 2'(op));
        end

        for (int i = 0; i < 400; i++)
            drive($urandom, $urandom, 2'($urandom_range(0, 3)));

        wait (q.size() == 0);
        @(posedge clk);
        #0.5;
        // R11: inputs change between edges, outputs follow with no clock edge.
        op_a = 32'h0000_0005; op_b = 32'h0000_0003; func_sel = 2'd1;
        #0.5;
        check(result == 32'h2, "R11", "async sub", result, 32'h2);
        op_a = 32'h0000_00FF; op_b = 32'h0000_000F; func_sel = 2'd3;
        #0.5;
        check(result == 32'hF0, "R11", "async xor", result, 32'hF0);
        #2;
        finish_run();
    end
endmodule